// File: doc/BRIEF.md
# Sync-Embedded Frame Player

This block plays a stored video frame out as a continuous stream of dots, one frame byte per dot clock. The nominal dot clock is 14.318 MHz. The output drives a four-bit RGBI colour monitor. The block has no timing generator of its own. Each stored byte holds its own horizontal and vertical sync flags next to its colour nibble. The frame image therefore carries the complete video timing, with the sync pulses painted into the overscan area. The active 640 by 200 picture sits at raster origin (0,0), so no centring is needed.

A raster walker steps through 912 dots per line and 262 lines per frame, which is 238,944 bytes per frame. It presents one linear address per clock to an external synchronous frame memory that has a read latency of one cycle. The returned byte is split into colour and sync. The colour is captured by an output register clocked on the falling clock edge, and that register can be cleared asynchronously through an active-low blanking input. The sync flags are captured on the same falling edge, so they stay aligned with the colour of the same byte. A synchronous play enable starts playback at address 0. While the enable is low, the walker is parked and every output is held low.

Top module: `svo_frame_player`

## Requirements
- R1: While `play_en` is high, `mem_addr` advances by exactly one on every rising clock edge, except at the last byte of the frame.
- R2: The horizontal position counts 0 to `H_TOTAL-1` (912 by default) and then wraps to 0, which also advances the line. A stored HSYNC flag that is painted once per line therefore repeats every `H_TOTAL` clocks.
- R3: After the last dot of line `V_TOTAL-1` (262 by default), both the line and `mem_addr` return to 0. A frame is `H_TOTAL*V_TOTAL` bytes, so a once-per-frame VSYNC flag repeats every `H_TOTAL*V_TOTAL` clocks.
- R4: Frame byte bits [3:0] appear on `rgbi[3:0]` unchanged, with R on bit 3, G on bit 2, B on bit 1 and I on bit 0. The memory returns the byte read at rising edge e during the cycle after e. `rgbi` captures it at the falling edge that follows e.
- R5: Frame byte bit 4 drives `hsync` and bit 5 drives `vsync`, both active-high. They are captured on the same falling edge as the colour of the same byte.
- R6: Frame byte bits 7 and 6 have no effect on any output.
- R7: While `blank_n` is low, `rgbi` is 0 immediately and asynchronously, and `hsync` and `vsync` keep following the frame data. After `blank_n` rises, the next falling edge shows the colour of the byte being fetched.
- R8: A rising edge that samples `play_en` low returns `mem_addr` and the raster position to 0. It also drives `rgbi`, `hsync` and `vsync` low at the following falling edge. Playback resumes from address 0, and the byte at address 0 is shown at the falling edge after the first rising edge that samples `play_en` high.
- R9: While `rst_n` is low, `mem_addr`, `rgbi`, `hsync` and `vsync` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock. Rising edge fetches, falling edge latches outputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| play_en | input | 1 | Synchronous playback enable. Low parks the walker at address 0 |
| blank_n | input | 1 | Asynchronous active-low clear of the colour register |
| mem_addr | output | ADDR_W | Linear frame-memory read address |
| mem_rdata | input | 8 | Frame byte returned one cycle after its address |
| rgbi | output | 4 | Latched colour: R, G, B, I on bits 3..0 |
| hsync | output | 1 | Latched horizontal sync flag from byte bit 4 |
| vsync | output | 1 | Latched vertical sync flag from byte bit 5 |

## Verification
Blanking and sync emission can fall in the same cycle. The clear acts only on the colour register, while the sync flags of the same byte still have to pass through. The bench provokes this by pulling `blank_n` low for a stretch of dots that contains a painted HSYNC run. Inside that stretch it checks that `rgbi` is zero immediately and on every dot, and that `hsync` and `vsync` still match the frame model. It also checks that the rise-to-rise spacing of HSYNC stays exactly one line. The line wrap and the frame wrap also coincide on the last dot of the frame. That case is judged by the address returning to 0 and by the byte at address 0 appearing on the next dot.

// File: rtl/svo_pkg.sv
package svo_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned COLOUR_W = 4;
  localparam int unsigned HS_POS   = 4;
  localparam int unsigned VS_POS   = 5;

  typedef struct packed {
    logic                vs;
    logic                hs;
    logic [COLOUR_W-1:0] colour;
  } svo_pix_t;

  function automatic svo_pix_t svo_unpack(input logic [BYTE_W-1:0] b);
    svo_pix_t p;
    p.colour = b[COLOUR_W-1:0];
    p.hs     = b[HS_POS];
    p.vs     = b[VS_POS];
    return p;
  endfunction
endpackage

// File: rtl/svo_reset_sync.sv
module svo_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/svo_raster_walker.sv
module svo_raster_walker #(
  parameter int unsigned H_TOTAL = 912,
  parameter int unsigned V_TOTAL = 262,
  localparam int unsigned FRAME  = H_TOTAL * V_TOTAL,
  localparam int unsigned H_W    = $clog2(H_TOTAL),
  localparam int unsigned V_W    = $clog2(V_TOTAL),
  localparam int unsigned ADDR_W = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [ADDR_W-1:0] addr,
  output logic              fetch_valid
);
  localparam logic [H_W-1:0]    H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0]    V_LAST = V_W'(V_TOTAL - 1);

  logic [H_W-1:0]    h_q, h_d;
  logic [V_W-1:0]    v_q, v_d;
  logic [ADDR_W-1:0] a_q, a_d;
  logic              val_q, val_d;
  logic              line_end, frame_end;

  assign line_end  = (h_q == H_LAST);
  assign frame_end = line_end && (v_q == V_LAST);

  always_comb begin
    h_d   = '0;
    v_d   = '0;
    a_d   = '0;
    val_d = run;
    if (run) begin
      if (line_end) begin
        h_d = '0;
        v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_d = h_q + 1'b1;
        v_d = v_q;
      end
      a_d = frame_end ? '0 : a_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= '0;
      a_q   <= '0;
      val_q <= 1'b0;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      a_q   <= a_d;
      val_q <= val_d;
    end
  end

  assign addr        = a_q;
  assign fetch_valid = val_q;

  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> (a_q == $past(a_q) + 1'b1));
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end && !frame_end) |=> (h_q == '0 && v_q == $past(v_q) + 1'b1));
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_end) |=> (a_q == '0 && v_q == '0 && h_q == '0));
  a_r3_origin_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q == '0 && v_q == '0) |-> (a_q == '0));
  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (a_q == '0 && h_q == '0 && v_q == '0 && !val_q));
endmodule

// File: rtl/svo_colour_latch.sv
module svo_colour_latch #(
  parameter int unsigned COLOUR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blank_n,
  input  logic                load_valid,
  input  logic [COLOUR_W-1:0] colour_in,
  output logic [COLOUR_W-1:0] rgbi
);
  logic [COLOUR_W-1:0] col_d, col_q;

  always_comb begin
    col_d = load_valid ? colour_in : '0;
  end

  always_ff @(negedge clk or negedge rst_n or negedge blank_n) begin
    if (!rst_n)        col_q <= '0;
    else if (!blank_n) col_q <= '0;
    else               col_q <= col_d;
  end

  assign rgbi = col_q;

  a_r7_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (rgbi == '0));
endmodule

// File: rtl/svo_sync_latch.sv
module svo_sync_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load_valid,
  input  logic hs_in,
  input  logic vs_in,
  output logic hsync,
  output logic vsync
);
  logic hs_d, vs_d, hs_q, vs_q;

  always_comb begin
    hs_d = load_valid && hs_in;
    vs_d = load_valid && vs_in;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      vs_q <= vs_d;
    end
  end

  assign hsync = hs_q;
  assign vsync = vs_q;
endmodule

// File: rtl/svo_frame_player.sv
module svo_frame_player
  import svo_pkg::*;
#(
  parameter int unsigned H_TOTAL = 912,
  parameter int unsigned V_TOTAL = 262,
  localparam int unsigned ADDR_W = $clog2(H_TOTAL * V_TOTAL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                play_en,
  input  logic                blank_n,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [COLOUR_W-1:0] rgbi,
  output logic                hsync,
  output logic                vsync
);
  logic     rst_n_int;
  logic     fetch_valid;
  svo_pix_t pix;
  logic     unused_hi;

  svo_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  svo_raster_walker #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .run         (play_en),
    .addr        (mem_addr),
    .fetch_valid (fetch_valid)
  );

  assign pix       = svo_unpack(mem_rdata);
  assign unused_hi = ^mem_rdata[BYTE_W-1:VS_POS+1];

  svo_colour_latch #(.COLOUR_W(COLOUR_W)) u_col (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .blank_n    (blank_n),
    .load_valid (fetch_valid),
    .colour_in  (pix.colour),
    .rgbi       (rgbi)
  );

  svo_sync_latch u_sync (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_valid (fetch_valid),
    .hs_in      (pix.hs),
    .vs_in      (pix.vs),
    .hsync      (hsync),
    .vsync      (vsync)
  );

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    !fetch_valid |-> (rgbi == '0 && !hsync && !vsync));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (mem_addr == '0 && rgbi == '0 && !hsync && !vsync));
endmodule

// File: tb/svo_frame_player_test.sv
`timescale 1ns/100ps
module svo_frame_player_test;
  localparam int H = 16;
  localparam int V = 6;
  localparam int FR = H * V;

  logic       clk = 1'b0;
  logic       rst_n, play_en, blank_n;
  logic [6:0] mem_addr;
  logic [7:0] mem_rdata;
  logic [3:0] rgbi;
  logic       hsync, vsync;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  svo_frame_player #(.H_TOTAL(H), .V_TOTAL(V)) uut (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .blank_n(blank_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rgbi(rgbi), .hsync(hsync), .vsync(vsync)
  );

  // Frame model: bits 3:0 colour = (h+v) mod 16, bit 4 HSYNC on dots 12..13,
  // bit 5 VSYNC on line 4, bits 7:6 junk taken from the address (R6).
  function automatic logic [7:0] frame_byte(input int a);
    int h, v;
    logic [3:0] c;
    h = a % H;
    v = a / H;
    c = 4'((h + v) & 15);
    return {2'(a & 3), (v == 4), (h == 12 || h == 13), c};
  endfunction

  always @(posedge clk) mem_rdata <= frame_byte(int'(mem_addr));

  // {n, rgbi, hsync, vsync} after playback starts at address 0
  localparam logic [21:0] VEC [11] = '{
    {16'd0,   4'h0, 1'b0, 1'b0},
    {16'd5,   4'h5, 1'b0, 1'b0},
    {16'd12,  4'hC, 1'b1, 1'b0},
    {16'd15,  4'hF, 1'b0, 1'b0},
    {16'd16,  4'h1, 1'b0, 1'b0},
    {16'd29,  4'hE, 1'b1, 1'b0},
    {16'd66,  4'h6, 1'b0, 1'b1},
    {16'd77,  4'h1, 1'b1, 1'b1},
    {16'd95,  4'h4, 1'b0, 1'b0},
    {16'd96,  4'h0, 1'b0, 1'b0},
    {16'd108, 4'hC, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int last_hs, last_vs;
    logic prev_hs, prev_vs;
    logic [7:0] b;
    rst_n = 1'b0; play_en = 1'b0; blank_n = 1'b1;
    tick(); tick();
    check(rgbi == 0, "R9 reset rgbi", rgbi, 0);
    check(!hsync && !vsync, "R9 reset sync", {hsync, vsync}, 0);
    check(mem_addr == 0, "R9 reset addr", mem_addr, 0);
    rst_n = 1'b1;
    tick(); tick(); tick(); tick();
    check(rgbi == 0 && !hsync && !vsync, "R8 idle outputs low", {rgbi, hsync, vsync}, 0);

    play_en = 1'b1;
    last_hs = -1; last_vs = -1; prev_hs = 1'b0; prev_vs = 1'b0;
    for (int n = 0; n < 300; n++) begin
      tick();
      b = frame_byte(n % FR);
      for (int k = 0; k < 11; k++) begin
        if (int'(VEC[k][21:6]) == n) begin
          check(rgbi == VEC[k][5:2], "R2 R3 R4 table rgbi", rgbi, VEC[k][5:2]);
          check(hsync == VEC[k][1] && vsync == VEC[k][0], "R5 table sync",
                {hsync, vsync}, VEC[k][1:0]);
        end
      end
      if (n >= 130 && n < 142)
        check(rgbi == 0, "R7 blank rgbi", rgbi, 0);
      else
        check(rgbi == b[3:0], "R4 R6 colour", rgbi, b[3:0]);
      check(hsync == b[4] && vsync == b[5], "R5 R7 sync", {hsync, vsync}, b[5:4]);
      check(int'(mem_addr) == (n + 1) % FR, "R1 R3 address", mem_addr, (n + 1) % FR);
      if (hsync && !prev_hs) begin
        if (last_hs >= 0) check(n - last_hs == H, "R2 hsync period", n - last_hs, H);
        last_hs = n;
      end
      if (vsync && !prev_vs) begin
        if (last_vs >= 0) check(n - last_vs == FR, "R3 vsync period", n - last_vs, FR);
        last_vs = n;
      end
      prev_hs = hsync; prev_vs = vsync;
      if (n == 129) begin
        blank_n = 1'b0;
        #0.4;
        check(rgbi == 0, "R7 asynchronous clear", rgbi, 0);
      end
      if (n == 141) blank_n = 1'b1;
    end

    play_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(rgbi == 0 && !hsync && !vsync, "R8 disabled outputs", {rgbi, hsync, vsync}, 0);
      check(mem_addr == 0, "R8 disabled addr", mem_addr, 0);
    end
    play_en = 1'b1;
    tick();
    check(rgbi == 0 && mem_addr == 1, "R8 restart byte 0", {rgbi, mem_addr}, 1);
    tick();
    check(rgbi == 4'h1, "R8 restart byte 1", rgbi, 1);
    tick();
    check(rgbi == 4'h2, "R8 restart byte 2", rgbi, 2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule